// File: doc/BRIEF.md
# Block Move and Search Sequencer

This block carries out one element of a memory block instruction each time it is started. A load element reads a byte at the source pointer and writes it to the destination pointer. A compare element reads the byte at the source pointer and subtracts it from the accumulator, without storing the result. Both kinds step their pointers up or down by one and count the 16-bit length register down by one. Both rebuild the flag byte, including the two undocumented bits that hold copies of intermediate arithmetic bits.

The surrounding instruction controller loads the operands and pulses `start_i`. It then waits for `done_o` and takes back the updated pointers, counter and flags. It also takes the T-state charge and a repeat indication. When `repeat_o` is high, the controller moves the program counter back by two and starts the engine again with the returned operands. The memory port is single-ported and registered: read data comes back in the cycle after the read strobe.

Top module: `blkxfer_engine`

## Requirements
- R1: `start_i` is taken only while the engine is idle. A start pulse or operand change while an element is in progress has no effect on that element and launches no second one.
- R2: `op_i` is decoded as follows: bit 2 means repeating, bit 1 means compare (0 = load), and bit 0 means decrement. A load reads the source address and writes that byte to the destination address, and `done_o` rises on the fourth clock edge after the accepting edge. A compare reads only, and `done_o` rises on the third edge.
- R3: Both pointers move by +1 when bit 0 = 0 and by -1 when bit 0 = 1, wrapping modulo 2^16. A compare returns the destination pointer unchanged.
- R4: The counter returns as its input minus one, modulo 2^16, so 0x0000 becomes 0xFFFF.
- R5: Load flags: the input flags are ANDed with 0xC1, and bit 2 is set when the returned counter is nonzero. With n = A + data mod 256, bit 3 = n[3] and bit 5 = n[1].
- R6: Compare flags, with r = A - data mod 256: bit 0 is kept from the input and bit 1 = 1. Bit 4 = bit 4 of (A ^ data ^ r). Bit 6 is set when r = 0, bit 7 = r[7], and bit 2 is set when the returned counter is nonzero.
- R7: Compare undocumented bits: with n = A - data - bit4 mod 256, bit 3 = n[3] and bit 5 = n[1].
- R8: `repeat_o` is high only for a repeating op with a nonzero returned counter. A repeating compare also needs r != 0. A non-repeating op never sets it.
- R9: `tstates_o` is 21 when `repeat_o` is high and 16 otherwise.
- R10: While `rst_n` is low at a clock edge, all outputs are cleared and the memory strobes stay low. An element interrupted by reset never signals done.
- R11: A compare never asserts `mem_we_o`. Read and write strobes are never high together, and `done_o` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one element (taken when idle) |
| op_i | input | 3 | {repeat, compare, decrement} |
| src_i | input | 16 | Source pointer |
| dst_i | input | 16 | Destination pointer |
| cnt_i | input | 16 | Length counter |
| acc_i | input | 8 | Accumulator |
| flags_i | input | 8 | Flag byte before the element |
| mem_addr_o | output | 16 | Memory address |
| mem_re_o | output | 1 | Read strobe; data valid next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle element completion pulse |
| src_o | output | 16 | Updated source pointer |
| dst_o | output | 16 | Updated destination pointer |
| cnt_o | output | 16 | Updated counter |
| flags_o | output | 8 | Updated flag byte |
| repeat_o | output | 1 | Instruction must re-execute |
| tstates_o | output | 5 | T-states charged for this element |

## Verification
The assertions assume a memory that returns the addressed byte in the cycle after `mem_re_o` and performs writes in the strobe cycle. They also assume reset is held from the first edge, so that the write-after-read check only sees strobes produced by the sequencer. The bench memory is a registered 256-byte array with exactly that latency. Every vector places source and destination at different low address bytes, so a written byte can never be mistaken for the preloaded source. A sentinel at the destination exposes any write a compare might make.

// File: rtl/blk_pkg.sv
// Package: shared types and fixed flag-bit positions for the block
// move and search sequencer. Bit positions are architectural and are
// decoded by the consumer of the flag byte.
package blk_pkg;

    // Flag byte bit positions
    localparam int FLG_C  = 0;
    localparam int FLG_N  = 1;
    localparam int FLG_PV = 2;
    localparam int FLG_Y  = 3;
    localparam int FLG_H  = 4;
    localparam int FLG_X  = 5;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 7;

    // Bits of the intermediate value copied into the undocumented flags
    localparam int UND_SRC_Y = 3;
    localparam int UND_SRC_X = 1;

    // Bit whose borrow becomes the half flag
    localparam int HALF_BIT = 4;

    // Operation word: repeat / compare / decrement
    typedef struct packed {
        logic rep;
        logic cmp;
        logic dec;
    } blk_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LATCH,
        ST_WRITE,
        ST_COMMIT
    } blk_state_t;

endpackage

// File: rtl/blk_step_unit.sv
// Module: blk_step_unit
// Computes the next source and destination pointers and the next
// counter value for one element. Pure combinational logic.
// Assumes: pointer and counter arithmetic wraps modulo its width.
module blk_step_unit #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              dec_i,
    input  logic              cmp_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              cnt_nz_o
);

    localparam logic [ADDR_W-1:0] STRIDE_UP = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STRIDE_DN = '1;

    logic [ADDR_W-1:0] stride_w;

    // Choose +1 or -1 (all ones) as the pointer stride
    always_comb begin
        stride_w = dec_i ? STRIDE_DN : STRIDE_UP;
    end

    // Step pointers; searches leave the destination alone
    always_comb begin
        src_o = src_i + stride_w;
        dst_o = cmp_i ? dst_i : (dst_i + stride_w);
    end

    // Count down and flag a nonzero remainder
    always_comb begin
        cnt_o    = cnt_i - CNT_W'(1);
        cnt_nz_o = |cnt_o;
    end

endmodule

// File: rtl/blk_flag_unit.sv
// Module: blk_flag_unit
// Builds the flag byte for a load or compare element, including the
// two undocumented bits taken from an intermediate sum or difference.
// Also reports whether the compare found a match.
// Assumes: DATA_W is at least 8 so that all flag positions exist.
module blk_flag_unit
    import blk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              cmp_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic              cnt_nz_i,
    output logic [DATA_W-1:0] flags_o,
    output logic              match_o
);

    localparam logic [DATA_W-1:0] HALF_MASK = DATA_W'(1) << HALF_BIT;
    localparam logic [DATA_W-1:0] Y_MASK    = DATA_W'(1) << UND_SRC_Y;
    localparam logic [DATA_W-1:0] X_MASK    = DATA_W'(1) << UND_SRC_X;
    localparam logic [DATA_W-1:0] KEEP_MASK = (DATA_W'(1) << FLG_S) |
                                              (DATA_W'(1) << FLG_Z) |
                                              (DATA_W'(1) << FLG_C);

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] diff_w;
    logic [DATA_W-1:0] bvec_w;
    logic [DATA_W-1:0] adj_w;
    logic [DATA_W-1:0] nsel_w;
    logic              half_w;

    // Arithmetic datapath: sum for loads, difference and adjusted difference for compares
    always_comb begin
        sum_w  = acc_i + data_i;
        diff_w = acc_i - data_i;
        bvec_w = acc_i ^ data_i ^ diff_w;
        half_w = |(bvec_w & HALF_MASK);
        adj_w  = diff_w - DATA_W'(half_w);
        nsel_w = cmp_i ? adj_w : sum_w;
    end

    // Match detect for the search repeat condition
    always_comb begin
        match_o = (diff_w == '0);
    end

    // Assemble the flag byte
    always_comb begin
        if (cmp_i) begin
            flags_o         = '0;
            flags_o[FLG_C]  = flags_i[FLG_C];
            flags_o[FLG_N]  = 1'b1;
            flags_o[FLG_H]  = half_w;
            flags_o[FLG_Z]  = (diff_w == '0);
            flags_o[FLG_S]  = diff_w[DATA_W-1];
        end else begin
            flags_o         = flags_i & KEEP_MASK;
        end
        flags_o[FLG_PV] = cnt_nz_i;
        flags_o[FLG_Y]  = |(nsel_w & Y_MASK);
        flags_o[FLG_X]  = |(nsel_w & X_MASK);
    end

endmodule

// File: rtl/blk_seq_ctrl.sv
// Module: blk_seq_ctrl
// Sequencer for one element: read strobe, data capture, optional
// write, then commit of results.
// Assumes: memory read data is valid in the cycle after the read strobe.
module blk_seq_ctrl
    import blk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cmp_i,
    output logic accept_o,
    output logic mem_re_o,
    output logic latch_o,
    output logic mem_we_o,
    output logic commit_o
);

    blk_state_t state_q;
    blk_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_READ;
            ST_READ:   state_d = ST_LATCH;
            ST_LATCH:  state_d = cmp_i ? ST_COMMIT : ST_WRITE;
            ST_WRITE:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decode per-state strobes
    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i;
        mem_re_o = (state_q == ST_READ);
        latch_o  = (state_q == ST_LATCH);
        mem_we_o = (state_q == ST_WRITE);
        commit_o = (state_q == ST_COMMIT);
    end

    // R11
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !cmp_i);

    // R2
    rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_re_o, 2));

endmodule

// File: rtl/blkxfer_engine.sv
// Module: blkxfer_engine (top)
// Runs one element of a block load or block compare per start pulse.
// It returns updated pointers, counter and flags, a repeat request and
// the T-state charge.
// Assumes: a single-ported registered memory (read data one cycle after
// mem_re_o, write in the strobe cycle); the controller re-issues while
// repeat_o is high.
module blkxfer_engine
    import blk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int T_LOOP = 21,
    parameter int T_LAST = 16,
    parameter int TS_W   = $clog2(T_LOOP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] flags_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DATA_W-1:0] flags_o,
    output logic              repeat_o,
    output logic [TS_W-1:0]   tstates_o
);

    localparam logic [TS_W-1:0] TS_LOOP = TS_W'(T_LOOP);
    localparam logic [TS_W-1:0] TS_LAST = TS_W'(T_LAST);

    blk_op_t           op_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] flg_q;
    logic [DATA_W-1:0] data_q;

    logic              accept_w;
    logic              latch_w;
    logic              commit_w;

    logic [ADDR_W-1:0] src_n_w;
    logic [ADDR_W-1:0] dst_n_w;
    logic [CNT_W-1:0]  cnt_n_w;
    logic              cnt_nz_w;
    logic [DATA_W-1:0] flags_n_w;
    logic              match_w;
    logic              rep_w;

    blk_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmp_i    (op_q.cmp),
        .accept_o (accept_w),
        .mem_re_o (mem_re_o),
        .latch_o  (latch_w),
        .mem_we_o (mem_we_o),
        .commit_o (commit_w)
    );

    blk_step_unit #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_step (
        .dec_i    (op_q.dec),
        .cmp_i    (op_q.cmp),
        .src_i    (src_q),
        .dst_i    (dst_q),
        .cnt_i    (cnt_q),
        .src_o    (src_n_w),
        .dst_o    (dst_n_w),
        .cnt_o    (cnt_n_w),
        .cnt_nz_o (cnt_nz_w)
    );

    blk_flag_unit #(
        .DATA_W (DATA_W)
    ) u_flags (
        .cmp_i    (op_q.cmp),
        .acc_i    (acc_q),
        .data_i   (data_q),
        .flags_i  (flg_q),
        .cnt_nz_i (cnt_nz_w),
        .flags_o  (flags_n_w),
        .match_o  (match_w)
    );

    // Operand capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            acc_q <= '0;
            flg_q <= '0;
        end else if (accept_w) begin
            op_q  <= blk_op_t'(op_i);
            src_q <= src_i;
            dst_q <= dst_i;
            cnt_q <= cnt_i;
            acc_q <= acc_i;
            flg_q <= flags_i;
        end
    end

    // Capture the byte returned by memory
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (latch_w) data_q <= mem_rdata_i;
    end

    // Memory port: write goes to the destination, reads come from the source
    always_comb begin
        mem_addr_o  = mem_we_o ? dst_q : src_q;
        mem_wdata_o = data_q;
    end

    // Repeat rule: moves loop on a nonzero count, searches also need a mismatch
    always_comb begin
        rep_w = op_q.rep && cnt_nz_w && !(op_q.cmp && match_w);
    end

    // Result registers and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            src_o     <= '0;
            dst_o     <= '0;
            cnt_o     <= '0;
            flags_o   <= '0;
            repeat_o  <= 1'b0;
            tstates_o <= '0;
        end else begin
            done_o <= commit_w;
            if (commit_w) begin
                src_o     <= src_n_w;
                dst_o     <= dst_n_w;
                cnt_o     <= cnt_n_w;
                flags_o   <= flags_n_w;
                repeat_o  <= rep_w;
                tstates_o <= rep_w ? TS_LOOP : TS_LAST;
            end
        end
    end

    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re_o && mem_we_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    rep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && repeat_o) |-> (cnt_o != '0));

    // R8
    rep_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && repeat_o && op_q.cmp) |-> !flags_o[FLG_Z]);

    // R3
    cmp_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q.cmp) |-> (dst_o == dst_q));

    // R5
    ld_hn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !op_q.cmp) |-> (!flags_o[FLG_H] && !flags_o[FLG_N]));

    // R6
    pv_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o[FLG_PV] == (cnt_o != '0)));

    // R9
    tstate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((tstates_o == TS_LOOP) || (tstates_o == TS_LAST)));

endmodule

// File: tb/blkxfer_engine_tb.sv
`timescale 1ns/1ps
module blkxfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [15:0] cnt_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  flags_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_re_o;
    logic        mem_we_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic        done_o;
    logic [15:0] src_o;
    logic [15:0] dst_o;
    logic [15:0] cnt_o;
    logic [7:0]  flags_o;
    logic        repeat_o;
    logic [4:0]  tstates_o;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    bit finished = 0;

    logic [7:0] mem [0:255];

    always #4 clk = ~clk;

    blkxfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .acc_i(acc_i),
        .flags_i(flags_i), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .src_o(src_o),
        .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o),
        .repeat_o(repeat_o), .tstates_o(tstates_o)
    );

    // Registered memory model: read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
        if (mem_we_o) begin
            mem[mem_addr_o[7:0]] <= mem_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // Vector: op, src, dst, cnt, acc, flags_in, data, expected flags, expected repeat
    localparam logic [83:0] VEC [8] = '{
        {3'b000, 16'h0010, 16'h0020, 16'h0003, 8'h00, 8'hFF, 8'h0A, 8'hED, 1'b0},
        {3'b001, 16'h0000, 16'h0040, 16'h0001, 8'h7F, 8'h00, 8'h01, 8'h00, 1'b0},
        {3'b100, 16'h0031, 16'h0051, 16'h0002, 8'h10, 8'h3E, 8'h22, 8'h24, 1'b1},
        {3'b101, 16'h0061, 16'h0071, 16'h0001, 8'h80, 8'h41, 8'h80, 8'h41, 1'b0},
        {3'b010, 16'h0081, 16'h0091, 16'h0004, 8'h55, 8'h01, 8'h55, 8'h47, 1'b0},
        {3'b011, 16'h00A1, 16'h00B1, 16'h0010, 8'h10, 8'h00, 8'h08, 8'h36, 1'b0},
        {3'b110, 16'hFFFF, 16'h00C1, 16'h0000, 8'h20, 8'h00, 8'h30, 8'h86, 1'b1},
        {3'b111, 16'h00D1, 16'h00E1, 16'h0005, 8'h42, 8'h01, 8'h42, 8'h47, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Drive operands and a one-cycle start pulse
    task automatic launch(input logic [2:0] op, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input logic [7:0] a, input logic [7:0] f);
        @(negedge clk);
        op_i = op; src_i = s; dst_i = d; cnt_i = c; acc_i = a; flags_i = f;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Count negedges from the one after the accepting edge until done
    task automatic wait_done(output int lat);
        lat = 1;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (!done_o) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual no done expected done");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 global watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", done_o, 0);
        chk("R10 src", src_o, 0);
        chk("R10 flags", flags_o, 0);
        chk("R10 repeat", repeat_o, 0);
        chk("R10 strobes", {mem_re_o, mem_we_o}, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 8; i++) begin
            logic [2:0]  op;
            logic [15:0] s, d, c, es, ed, ec;
            logic [7:0]  a, f, dat, ef;
            logic        er;
            int          lat, wr0;
            {op, s, d, c, a, f, dat, ef, er} = VEC[i];
            mem[s[7:0]] = dat;
            mem[d[7:0]] = 8'hEE;
            wr0 = wr_cnt;
            launch(op, s, d, c, a, f);
            wait_done(lat);
            es = op[0] ? s - 16'd1 : s + 16'd1;
            ed = op[1] ? d : (op[0] ? d - 16'd1 : d + 16'd1);
            ec = c - 16'd1;
            chk("R2 latency", lat - 1, op[1] ? 3 : 4);
            chk("R3 src", src_o, es);
            chk("R3 dst", dst_o, ed);
            chk("R4 cnt", cnt_o, ec);
            if (op[1]) begin
                chk("R6 flags", flags_o, ef);
                chk("R7 undoc", flags_o & 8'h28, ef & 8'h28);
                chk("R11 no write", wr_cnt - wr0, 0);
                chk("R11 dest kept", mem[d[7:0]], 8'hEE);
            end else begin
                chk("R5 flags", flags_o, ef);
                chk("R2 one write", wr_cnt - wr0, 1);
                chk("R2 dest data", mem[d[7:0]], dat);
            end
            chk("R8 repeat", repeat_o, er);
            chk("R9 tstates", tstates_o, er ? 21 : 16);
            @(negedge clk);
            chk("R11 done pulse", done_o, 0);
        end

        // R1 start and operand change while busy are ignored
        begin
            int dones = 0;
            logic [15:0] s_seen = '0;
            mem[8'h05] = 8'h5A;
            mem[8'h06] = 8'hEE;
            launch(3'b000, 16'h0005, 16'h0006, 16'h0002, 8'h00, 8'h00);
            start_i = 1'b1; op_i = 3'b010; src_i = 16'h0077;
            @(negedge clk);
            start_i = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (done_o) begin dones++; s_seen = src_o; end
                @(negedge clk);
            end
            chk("R1 single done", dones, 1);
            chk("R1 src kept", s_seen, 16'h0006);
            chk("R1 dest data", mem[8'h06], 8'h5A);
        end

        // R10 reset in the middle of an element
        begin
            int dones = 0;
            launch(3'b000, 16'h0008, 16'h0009, 16'h0003, 8'h00, 8'h00);
            rst_n = 1'b0;
            @(negedge clk);
            chk("R10 mid cnt", cnt_o, 0);
            rst_n = 1'b1;
            for (int k = 0; k < 8; k++) begin
                if (done_o) dones++;
                @(negedge clk);
            end
            chk("R10 no done", dones, 0);
        end

        summary();
        $finish;
    end

endmodule